// File: doc/BRIEF.md
# PCI Configuration Address Translator

This block sits behind a local-bus window for downstream configuration space. It turns each local access into a PCI Type 0 configuration cycle request. A 16-bit window offset is joined to a 16-bit programmable upper-address value, which gives a 32-bit intermediate address. The upper part of that address carries a one-hot device-select pattern. The block finds the device number from the position of the lowest set bit in that pattern. It then builds the configuration address from four parts: a static bus number, that device number, the function field and the register field. The enable bit is set in the result.

The block holds one request at a time on a simple req/ack port to the downstream side. It returns a response pulse with read data to the local bus. Some accesses cannot be translated: the mapping value asks for a non-Type 0 mode, the device-select pattern is empty, or the size or alignment of the access is illegal. These accesses never reach the downstream port. Reads of this kind complete at once with all ones and writes are dropped. An empty device-select pattern also sets a sticky error flag. The block keeps a two-bit abort status from the last translated access.

Top module: `pci_cfg_xlate`

## Requirements
- R1: A translated request carries dnAddr with bit 31 = 1, bits [30:24] = 0, bits [23:16] = busNum, bits [15:11] = device number, bits [10:8] = intermediate bits [10:8], bits [7:2] = intermediate bits [7:2], and bits [1:0] = 0. The intermediate address is {mapReg[15:0], reqOffset}.
- R2: The device number is the index of the lowest set bit of intermediate bits [31:11], with bit 11 as index 0. When several bits are set, the lowest one wins.
- R3: When mapReg[16] = 1, no downstream request is made. A read responds with all ones in the access width and a write responds with 0. The error flag is not changed.
- R4: When mapReg[16] = 0 and intermediate bits [31:11] are all zero, no downstream request is made. idselErr is set and stays set until reset. A read responds with all ones in the access width.
- R5: reqSize is a byte count. Size 1 at offset bits [1:0] = k gives dnByteEn = 1<<k. Size 2 at an even k gives 3<<k. Size 4 at k = 0 gives 4'hF. Any other size, and any misaligned size 2 or size 4, is rejected with no request. Such a read returns 32'hFF for size 1, 32'hFFFF for size 2 and 32'hFFFFFFFF otherwise.
- R6: dnReq rises in the cycle after an access is accepted. It stays high with dnAddr, dnByteEn and dnWdata stable until a cycle with dnAck. reqReady is low from acceptance until the response cycle has passed.
- R7: rspValid is a one-cycle pulse. It comes in the cycle after dnAck for a translated access, or in the cycle after acceptance for a rejected one. For a translated read, rspRdata is dnRdata masked to the access width. For a write, rspRdata is 0.
- R8: abortStat (bit 0 = master abort, bit 1 = target abort) is cleared when a translated request is launched. It is loaded from dnMabort and dnTabort at dnAck. Rejected accesses leave it unchanged.
- R9: After reset, reqReady = 1, dnReq = 0, rspValid = 0, idselErr = 0 and abortStat = 0.
- R10: A translated write drives dnWrite = 1 and dnWdata equal to reqWdata. A translated read drives dnWrite = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Local access present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 16 | Offset inside the configuration window |
| reqSize | input | 3 | Access size in bytes |
| reqWdata | input | 32 | Local write data |
| reqReady | output | 1 | Block can accept an access |
| mapReg | input | 17 | [15:0] upper address bits, [16] non-Type 0 mode |
| busNum | input | 8 | Static bus number |
| rspValid | output | 1 | Response pulse to the local bus |
| rspRdata | output | 32 | Response read data |
| dnReq | output | 1 | Downstream configuration request |
| dnWrite | output | 1 | Downstream direction |
| dnAddr | output | 32 | Formed configuration address with enable bit |
| dnByteEn | output | 4 | Downstream byte lanes |
| dnWdata | output | 32 | Downstream write data |
| dnAck | input | 1 | Downstream completion |
| dnRdata | input | 32 | Downstream read data |
| dnMabort | input | 1 | Master abort seen on the completion |
| dnTabort | input | 1 | Target abort seen on the completion |
| abortStat | output | 2 | Abort status of the last translated access |
| idselErr | output | 1 | Sticky empty device-select error |

## Verification
A wrong state register shows up at once on the handshake pins. A stuck or skipped state gives a reqReady, dnReq or rspValid pattern that departs from the reference within one cycle of acceptance or acknowledge. A wrong device encoder or field slice cannot hide in internal state: it appears on dnAddr in the first cycle of the request. Mask and status errors appear in the response cycle or on abortStat right after the launch or ack edge. The bench therefore compares every output with a behavioural model on every clock, so the first wrong cycle is reported.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int DATA_W    = 32;
  localparam int OFF_W     = 16;
  localparam int MAP_W     = 17;
  localparam int MODE_BIT  = 16;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int FN_W      = 3;
  localparam int REG_W     = 6;
  localparam int SIZE_W    = 3;
  localparam int BE_W      = DATA_W / 8;
  localparam int LANE_W    = $clog2(BE_W);
  localparam int IDSEL_LSB = REG_W + FN_W + LANE_W;
  localparam int IDSEL_W   = DATA_W - IDSEL_LSB;
  localparam int RSV_W     = DATA_W - 1 - BUS_W - DEV_W - FN_W - REG_W - LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RESP = 2'd2
  } xlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic launch;
    logic rejectRsp;
    logic ackRsp;
    logic flagErr;
  } xlStrobe_t;

  // Decode results from datapath to control
  typedef struct packed {
    logic modeBad;
    logic shapeBad;
    logic idselZero;
  } xlDecode_t;
endpackage

// File: rtl/cfgx_low_enc.sv
module cfgx_low_enc #(
  parameter int W  = 21,
  parameter int IW = 5
) (
  input  logic [W-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          none
);
  logic [W:0]   below;
  logic [W-1:0] hit;

  assign below[0] = 1'b0;

  generate
    for (genvar g = 0; g < W; g++) begin : gChain
      assign below[g+1] = below[g] | vec[g];
      assign hit[g]     = vec[g] & ~below[g];
    end
  endgenerate

  assign none = ~below[W];

  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (hit[i]) idx = idx | IW'(i);
    end
  end
endmodule

// File: rtl/cfgx_datapath.sv
module cfgx_datapath
  import cfgx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqWrite,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [MAP_W-1:0]    mapReg,
  input  logic [BUS_W-1:0]    busNum,
  input  logic [DATA_W-1:0]   dnRdata,
  input  logic                dnMabort,
  input  logic                dnTabort,
  input  xlStrobe_t           stb,
  output xlDecode_t           decode,
  output logic [DATA_W-1:0]   dnAddr,
  output logic [BE_W-1:0]     dnByteEn,
  output logic                dnWrite,
  output logic [DATA_W-1:0]   dnWdata,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [1:0]          abortStat,
  output logic                idselErr
);
  logic [DATA_W-1:0]  formedAddr;
  logic [IDSEL_W-1:0] idselField;
  logic [DEV_W-1:0]   devNum;
  logic               idselNone;
  logic [LANE_W-1:0]  laneOff;
  logic [BE_W-1:0]    laneEn;
  logic               shapeOk;
  logic [DATA_W-1:0]  onesMask;
  logic [DATA_W-1:0]  pendMask;

  assign formedAddr = {mapReg[OFF_W-1:0], reqOffset};
  assign idselField = formedAddr[DATA_W-1:IDSEL_LSB];
  assign laneOff    = formedAddr[LANE_W-1:0];

  cfgx_low_enc #(.W(IDSEL_W), .IW(DEV_W)) uEnc (
    .vec  (idselField),
    .idx  (devNum),
    .none (idselNone)
  );

  // Lane enables and alignment check
  always_comb begin
    laneEn  = '0;
    shapeOk = 1'b0;
    case (reqSize)
      SIZE_W'(1): begin
        laneEn  = BE_W'(1) << laneOff;
        shapeOk = 1'b1;
      end
      SIZE_W'(2): begin
        laneEn  = BE_W'(3) << laneOff;
        shapeOk = ~laneOff[0];
      end
      SIZE_W'(BE_W): begin
        laneEn  = '1;
        shapeOk = (laneOff == '0);
      end
      default: begin
        laneEn  = '0;
        shapeOk = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (reqSize)
      SIZE_W'(1): onesMask = DATA_W'({8{1'b1}});
      SIZE_W'(2): onesMask = DATA_W'({16{1'b1}});
      default:    onesMask = '1;
    endcase
  end

  assign decode.modeBad   = mapReg[MODE_BIT];
  assign decode.shapeBad  = ~shapeOk;
  assign decode.idselZero = idselNone;

  // Request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dnAddr   <= '0;
      dnByteEn <= '0;
      dnWrite  <= 1'b0;
      dnWdata  <= '0;
      pendMask <= '0;
    end else if (stb.launch) begin
      dnAddr   <= {1'b1, {RSV_W{1'b0}}, busNum, devNum,
                   formedAddr[IDSEL_LSB-1:REG_W+LANE_W],
                   formedAddr[REG_W+LANE_W-1:LANE_W],
                   {LANE_W{1'b0}}};
      dnByteEn <= laneEn;
      dnWrite  <= reqWrite;
      dnWdata  <= reqWdata;
      pendMask <= onesMask;
    end
  end

  // Response data
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (stb.rejectRsp) begin
      rspRdata <= reqWrite ? '0 : onesMask;
    end else if (stb.ackRsp) begin
      rspRdata <= dnWrite ? '0 : (dnRdata & pendMask);
    end
  end

  // Abort status: cleared on launch, captured on ack
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      abortStat <= 2'b00;
    end else if (stb.launch) begin
      abortStat <= 2'b00;
    end else if (stb.ackRsp) begin
      abortStat <= {dnTabort, dnMabort};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idselErr <= 1'b0;
    end else if (stb.flagErr) begin
      idselErr <= 1'b1;
    end
  end
endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
  import cfgx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      dnAck,
  input  xlDecode_t decode,
  output xlStrobe_t stb,
  output logic      reqReady,
  output logic      dnReq,
  output logic      rspValid
);
  xlState_t state, stateNxt;

  always_comb begin
    stb      = '0;
    stateNxt = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (decode.modeBad || decode.shapeBad) begin
            stb.rejectRsp = 1'b1;
            stateNxt      = ST_RESP;
          end else if (decode.idselZero) begin
            stb.rejectRsp = 1'b1;
            stb.flagErr   = 1'b1;
            stateNxt      = ST_RESP;
          end else begin
            stb.launch = 1'b1;
            stateNxt   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (dnAck) begin
          stb.ackRsp = 1'b1;
          stateNxt   = ST_RESP;
        end
      end
      ST_RESP: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign reqReady = (state == ST_IDLE);
  assign dnReq    = (state == ST_WAIT);
  assign rspValid = (state == ST_RESP);
endmodule

// File: rtl/pci_cfg_xlate.sv
module pci_cfg_xlate
  import cfgx_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [SIZE_W-1:0]   reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqReady,
  input  logic [MAP_W-1:0]    mapReg,
  input  logic [BUS_W-1:0]    busNum,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspRdata,
  output logic                dnReq,
  output logic                dnWrite,
  output logic [DATA_W-1:0]   dnAddr,
  output logic [BE_W-1:0]     dnByteEn,
  output logic [DATA_W-1:0]   dnWdata,
  input  logic                dnAck,
  input  logic [DATA_W-1:0]   dnRdata,
  input  logic                dnMabort,
  input  logic                dnTabort,
  output logic [1:0]          abortStat,
  output logic                idselErr
);
  xlStrobe_t stb;
  xlDecode_t decode;

  cfgx_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .dnAck    (dnAck),
    .decode   (decode),
    .stb      (stb),
    .reqReady (reqReady),
    .dnReq    (dnReq),
    .rspValid (rspValid)
  );

  cfgx_datapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .reqWrite  (reqWrite),
    .reqOffset (reqOffset),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .mapReg    (mapReg),
    .busNum    (busNum),
    .dnRdata   (dnRdata),
    .dnMabort  (dnMabort),
    .dnTabort  (dnTabort),
    .stb       (stb),
    .decode    (decode),
    .dnAddr    (dnAddr),
    .dnByteEn  (dnByteEn),
    .dnWrite   (dnWrite),
    .dnWdata   (dnWdata),
    .rspRdata  (rspRdata),
    .abortStat (abortStat),
    .idselErr  (idselErr)
  );
endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk
  import cfgx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              modeBit,
  input logic              dnReq,
  input logic              dnAck,
  input logic [DATA_W-1:0] dnAddr,
  input logic [BE_W-1:0]   dnByteEn,
  input logic [DATA_W-1:0] dnWdata,
  input logic              rspValid,
  input logic [1:0]        abortStat,
  input logic              idselErr
);
  // R1
  enable_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnReq |-> (dnAddr[DATA_W-1] && dnAddr[LANE_W-1:0] == '0));

  // R3
  mode_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && modeBit) |=> !dnReq);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    idselErr |=> idselErr);

  // R5
  lanes_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnReq |-> (dnByteEn != '0));

  // R6
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && !dnAck) |=> (dnReq && $stable(dnAddr) && $stable(dnByteEn) && $stable(dnWdata)));

  // R6
  single_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    dnReq |-> !reqReady);

  // R7
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R7
  ack_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnReq && dnAck) |=> rspValid);

  // R8
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnReq) |-> (abortStat == 2'b00));
endmodule

bind pci_cfg_xlate cfgx_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .modeBit   (mapReg[cfgx_pkg::MODE_BIT]),
  .dnReq     (dnReq),
  .dnAck     (dnAck),
  .dnAddr    (dnAddr),
  .dnByteEn  (dnByteEn),
  .dnWdata   (dnWdata),
  .rspValid  (rspValid),
  .abortStat (abortStat),
  .idselErr  (idselErr)
);

// File: tb/sim_pci_cfg_xlate.sv
`timescale 1ns/1ps
module sim_pci_cfg_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqOffset = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        reqReady;
  logic [16:0] mapReg = '0;
  logic [7:0]  busNum = 8'h03;
  logic        rspValid;
  logic [31:0] rspRdata;
  logic        dnReq, dnWrite;
  logic [31:0] dnAddr, dnWdata;
  logic [3:0]  dnByteEn;
  logic        dnAck = 1'b0;
  logic [31:0] dnRdata = '0;
  logic        dnMabort = 1'b0, dnTabort = 1'b0;
  logic [1:0]  abortStat;
  logic        idselErr;

  int checkCnt = 0;
  int failCnt  = 0;

  always #4 clk = ~clk;

  pci_cfg_xlate u0 (.*);

  // Responder settings and last seen request
  int          respDelay = 1;
  int          waitCnt = 0;
  logic [31:0] respData = 32'h0;
  logic        respMab = 1'b0, respTab = 1'b0;
  logic [31:0] lastAddr = '0, lastWdata = '0, lastRsp = '0;
  logic [3:0]  lastBe = '0;
  logic        lastWrite = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference functions written from the requirements
  function automatic logic [31:0] refAddr(input logic [15:0] off, input logic [16:0] map, input logic [7:0] bus);
    logic [31:0] f;
    int dev;
    f = {map[15:0], off};
    dev = 0;
    for (int i = 31; i >= 11; i--) if (f[i]) dev = i - 11;
    return 32'h8000_0000 | (32'(bus) << 16) | (32'(dev) << 11) | (32'(f[10:8]) << 8) | (32'(f[7:2]) << 2);
  endfunction

  function automatic logic [31:0] refMask(input logic [2:0] sz);
    if (sz == 3'd1) return 32'h0000_00FF;
    if (sz == 3'd2) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] refBe(input logic [1:0] k, input logic [2:0] sz);
    if (sz == 3'd1) return 4'b0001 << k;
    if (sz == 3'd2 && !k[0]) return 4'b0011 << k;
    if (sz == 3'd4 && k == 2'd0) return 4'b1111;
    return 4'b0000;
  endfunction

  // Cycle model: 0 idle, 1 waiting, 2 responding
  int          mSt = 0;
  logic        mErr = 1'b0;
  logic [1:0]  mAbort = 2'b00;
  logic [31:0] mAddr = '0, mWd = '0, mRd = '0, mMask = '0;
  logic [3:0]  mBe = '0;
  logic        mWr = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mErr = 1'b0; mAbort = 2'b00;
    end else begin
      case (mSt)
        0: if (reqValid) begin
          logic [31:0] f;
          f = {mapReg[15:0], reqOffset};
          if (mapReg[16] || refBe(reqOffset[1:0], reqSize) == 4'b0000) begin
            mRd = reqWrite ? 32'h0 : refMask(reqSize);
            mSt = 2;
          end else if (f[31:11] == 21'h0) begin
            mRd = reqWrite ? 32'h0 : refMask(reqSize);
            mErr = 1'b1;
            mSt = 2;
          end else begin
            mAddr = refAddr(reqOffset, mapReg, busNum);
            mBe = refBe(reqOffset[1:0], reqSize);
            mWr = reqWrite; mWd = reqWdata; mMask = refMask(reqSize);
            mAbort = 2'b00;
            mSt = 1;
          end
        end
        1: if (dnAck) begin
          mRd = mWr ? 32'h0 : (dnRdata & mMask);
          mAbort = {dnTabort, dnMabort};
          mSt = 2;
        end
        default: mSt = 0;
      endcase
    end
  end

  // Compare every cycle
  always @(negedge clk) begin
    if (rstN) begin
      chk("R6 reqReady", 32'(reqReady), 32'(mSt == 0));
      chk("R6 dnReq", 32'(dnReq), 32'(mSt == 1));
      chk("R7 rspValid", 32'(rspValid), 32'(mSt == 2));
      chk("R4 idselErr", 32'(idselErr), 32'(mErr));
      chk("R8 abortStat", 32'(abortStat), 32'(mAbort));
      if (dnReq) begin
        chk("R1 dnAddr", dnAddr, mAddr);
        chk("R5 dnByteEn", 32'(dnByteEn), 32'(mBe));
        chk("R10 dnWrite", 32'(dnWrite), 32'(mWr));
        chk("R10 dnWdata", dnWdata, mWd);
      end
      if (rspValid) chk("R7 rspRdata", rspRdata, mRd);
    end
  end

  // Downstream responder
  always @(negedge clk) begin
    if (dnAck) begin
      dnAck = 1'b0;
    end else if (dnReq) begin
      if (waitCnt == 0) begin
        dnAck = 1'b1;
        dnRdata = respData; dnMabort = respMab; dnTabort = respTab;
        lastAddr = dnAddr; lastBe = dnByteEn; lastWrite = dnWrite; lastWdata = dnWdata;
      end else begin
        waitCnt--;
      end
    end else begin
      waitCnt = respDelay;
    end
  end

  task automatic access(input logic w, input logic [15:0] off, input logic [2:0] sz,
                        input logic [31:0] wd, input logic [16:0] map);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqOffset = off; reqSize = sz; reqWdata = wd; mapReg = map;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspValid) @(negedge clk);
    lastRsp = rspRdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reqReady", 32'(reqReady), 32'd1);
    chk("R9 dnReq", 32'(dnReq), 32'd0);
    chk("R9 rspValid", 32'(rspValid), 32'd0);
    chk("R9 idselErr", 32'(idselErr), 32'd0);
    chk("R9 abortStat", 32'(abortStat), 32'd0);

    // R1 field placement
    respDelay = 2; respData = 32'h1234_5678;
    access(1'b0, 16'h0248, 3'd4, 32'h0, 17'h0_0002);
    chk("R1 addr fields", lastAddr, 32'h8003_3248);
    chk("R7 read data", lastRsp, 32'h1234_5678);

    // R2 lowest set bit wins
    respDelay = 0;
    access(1'b0, 16'h0000, 3'd4, 32'h0, 17'h0_0006);
    chk("R2 two bits", lastAddr, 32'h8003_3000);
    access(1'b0, 16'h0800, 3'd4, 32'h0, 17'h0_0000);
    chk("R2 index zero", lastAddr, 32'h8003_0000);
    access(1'b0, 16'h0000, 3'd4, 32'h0, 17'h0_8000);
    chk("R2 top index", lastAddr, 32'h8003_A000);

    // R10 write path
    access(1'b1, 16'h0810, 3'd4, 32'hCAFE_F00D, 17'h0_0000);
    chk("R10 write flag", 32'(lastWrite), 32'd1);
    chk("R10 write data", lastWdata, 32'hCAFE_F00D);
    chk("R7 write rsp", lastRsp, 32'h0);

    // R3 non-Type 0 mode
    access(1'b0, 16'h0010, 3'd2, 32'h0, 17'h1_0002);
    chk("R3 read ones", lastRsp, 32'h0000_FFFF);
    access(1'b1, 16'h0010, 3'd4, 32'h5555_5555, 17'h1_0002);
    chk("R3 write rsp", lastRsp, 32'h0);
    chk("R3 no error", 32'(idselErr), 32'd0);

    // R5 lanes, masking, rejection
    respData = 32'hAABB_CCDD;
    access(1'b0, 16'h0803, 3'd1, 32'h0, 17'h0_0000);
    chk("R5 byte lane", 32'(lastBe), 32'h8);
    chk("R7 byte mask", lastRsp, 32'h0000_00DD);
    access(1'b0, 16'h0802, 3'd2, 32'h0, 17'h0_0000);
    chk("R5 half lanes", 32'(lastBe), 32'hC);
    chk("R7 half mask", lastRsp, 32'h0000_CCDD);
    access(1'b0, 16'h0801, 3'd2, 32'h0, 17'h0_0000);
    chk("R5 odd half", lastRsp, 32'h0000_FFFF);
    access(1'b0, 16'h0800, 3'd3, 32'h0, 17'h0_0000);
    chk("R5 size three", lastRsp, 32'hFFFF_FFFF);
    access(1'b0, 16'h0802, 3'd4, 32'h0, 17'h0_0000);
    chk("R5 misaligned word", lastRsp, 32'hFFFF_FFFF);

    // R8 abort status
    respMab = 1'b1;
    access(1'b0, 16'h0800, 3'd4, 32'h0, 17'h0_0000);
    @(negedge clk);
    chk("R8 master abort", 32'(abortStat), 32'h1);
    respMab = 1'b0; respTab = 1'b1; respDelay = 3;
    access(1'b0, 16'h0800, 3'd4, 32'h0, 17'h0_0000);
    @(negedge clk);
    chk("R8 target abort", 32'(abortStat), 32'h2);
    access(1'b0, 16'h0801, 3'd4, 32'h0, 17'h0_0000);
    @(negedge clk);
    chk("R8 reject keeps", 32'(abortStat), 32'h2);
    respTab = 1'b0;

    // R4 empty select pattern
    access(1'b0, 16'h0010, 3'd1, 32'h0, 17'h0_0000);
    chk("R4 read ones", lastRsp, 32'h0000_00FF);
    chk("R4 flag set", 32'(idselErr), 32'd1);
    access(1'b0, 16'h0900, 3'd4, 32'h0, 17'h0_0000);
    @(negedge clk);
    chk("R4 flag sticky", 32'(idselErr), 32'd1);

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule